// File: doc/BRIEF.md
# Signed Residue Scaler with Selectable Divisor

This block takes a signed integer held as four residues over the pairwise coprime base {7, 11, 13, 15}, whose dynamic range is M = 15015. It divides the integer by a divisor chosen per operand and returns the quotient, again as four residues, together with a flag that marks a negative operand. The divisor is always a product of some of the base moduli. A small select input picks which product is used.

Internally the operand is first turned into mixed-radix digits. Each pipeline stage peels off one digit with a bank of modular subtract-and-multiply cells. The order in which moduli are peeled off depends on the select. The moduli that make up the divisor go first, so the low-weight digits together cover exactly the divisor. Those digits are discarded and the remaining digits are rescaled, with no rounding error. The sign comes from the top digit, which is compared against a threshold. The comparison looks at the lower digits only when the top digit is equal to the threshold. A new operand can be accepted on every clock.

Top module: `rns_signed_scaler`

## Requirements
- R1: The input residues r_c (c = 0..3 for moduli 7, 11, 13, 15) name the unique X in [0, 15014] with X mod m_c = r_c. The signed value is Xs = X when X <= 7507 and Xs = X - 15015 otherwise.
- R2: For an accepted operand, each output residue out_res[c] equals floor(Xs / F) mod m_c, taken in the range 0..m_c-1, where F is the divisor chosen by the select.
- R3: The select maps to the divisor as follows: 0 -> 7, 1 -> 11, 2 -> 13, 3 -> 15, 4 -> 77, 5 -> 195, 6 -> 1001, 7 -> 165.
- R4: out_neg is 1 exactly when Xs < 0 for the operand that the result belongs to.
- R5: A result appears on out_vld exactly 5 clock cycles after its operand is sampled with in_vld high. Operands may arrive on every cycle, and none is lost or duplicated.
- R6: The select is sampled together with its operand and travels with it. Changing the select on every cycle gives each result its own divisor.
- R7: out_vld is 0 during reset and after it. It stays 0 while no operand is in flight, whatever in_res and in_sel hold while in_vld is low.
- R8: For a negative operand the quotient is rounded toward minus infinity. For example, Xs = -1 with F = 7 gives -1, and Xs = -8 gives -2.
- R9: The extreme operands -7507 and 7507, zero and -1 give the floor quotient for every select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand present this cycle |
| in_sel | input | 3 | Divisor select, see R3 |
| in_res | input | 4x4 | Operand residues, index c for modulus 7, 11, 13, 15 |
| out_vld | output | 1 | Result present this cycle |
| out_neg | output | 1 | Operand was negative |
| out_res | output | 4x4 | Quotient residues, same channel order as in_res |

## Verification
The assertions take for granted that every residue presented with in_vld high is already reduced, so r_c < m_c. The digit-range and output-range properties rely on that, and an input property flags a violation. All select codes are legal. The stimulus builds every operand by reducing a signed value in [-7507, 7507] with each modulus, so no illegal residue is ever driven while in_vld is high. During idle cycles it drives arbitrary residues and selects with in_vld low, and that tests only R7.

// File: rtl/rns_scl_pkg.sv
package rns_scl_pkg;

   parameter int unsigned CH   = 4;
   parameter int unsigned RW   = 4;
   parameter int unsigned MODS [CH] = '{7, 11, 13, 15};
   parameter int unsigned NSEL = 8;
   // each mask marks the moduli whose product forms the divisor of one select code
   parameter logic [CH-1:0] SEL_MASK [NSEL] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                               4'b0011, 4'b1100, 4'b0111, 4'b1010};

   localparam int unsigned SW   = $clog2(NSEL);
   localparam int unsigned CW   = $clog2(CH);
   localparam int unsigned LAT  = CH + 1;
   localparam int unsigned SUMW = $clog2(CH * (2**RW));

   function automatic int unsigned mod_of(int unsigned c);
      return MODS[c[CW-1:0]];
   endfunction

   function automatic int unsigned total_mod();
      int unsigned p = 1;
      for (int unsigned c = 0; c < CH; c++) p = p * mod_of(c);
      return p;
   endfunction

   localparam int unsigned MTOT = total_mod();
   localparam int unsigned HALF = (MTOT + 1) / 2;

   function automatic int unsigned gcd_u(int unsigned a, int unsigned b);
      int unsigned x = a;
      int unsigned y = b;
      int unsigned t;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic logic [CH-1:0] sel_mask(int unsigned s);
      return SEL_MASK[s[SW-1:0]];
   endfunction

   function automatic int unsigned ord_cnt(int unsigned s);
      return $countones(sel_mask(s));
   endfunction

   // physical channel used at mixed-radix position pos: divisor moduli first
   function automatic int unsigned ord_idx(int unsigned s, int unsigned pos);
      logic [CH-1:0] msk = sel_mask(s);
      int unsigned n = 0;
      int unsigned r = 0;
      for (int unsigned pass = 0; pass < 2; pass++)
         for (int unsigned c = 0; c < CH; c++)
            if (msk[c[CW-1:0]] == (pass == 0)) begin
               if (n == pos) r = c;
               n++;
            end
      return r;
   endfunction

   function automatic int unsigned mod_at(int unsigned s, int unsigned pos);
      return mod_of(ord_idx(s, pos));
   endfunction

   function automatic int unsigned weight(int unsigned s, int unsigned pos);
      int unsigned w = 1;
      for (int unsigned i = 0; i < CH; i++)
         if (i < pos) w = w * mod_at(s, i);
      return w;
   endfunction

   function automatic int unsigned factor(int unsigned s);
      return weight(s, ord_cnt(s));
   endfunction

   function automatic int unsigned inv_mod(int unsigned a, int unsigned m);
      int unsigned r = 0;
      for (int unsigned i = 1; i < 16; i++)
         if (i < m && ((a * i) % m) == 1) r = i;
      return r;
   endfunction

   function automatic int unsigned mrc_mul(int unsigned s, int unsigned pos, int unsigned c);
      if (ord_idx(s, pos) == c) return 0;
      return inv_mod(mod_at(s, pos) % mod_of(c), mod_of(c));
   endfunction

   function automatic int unsigned scl_coef(int unsigned s, int unsigned pos, int unsigned c);
      if (pos < ord_cnt(s)) return 0;
      return (weight(s, pos) / factor(s)) % mod_of(c);
   endfunction

   function automatic int unsigned neg_ofs(int unsigned s, int unsigned c);
      return (MTOT / factor(s)) % mod_of(c);
   endfunction

   function automatic int unsigned sgn_thr(int unsigned s);
      return HALF / weight(s, CH-1);
   endfunction

   function automatic int unsigned sgn_rem(int unsigned s);
      return HALF % weight(s, CH-1);
   endfunction

endpackage

// File: rtl/rns_modcell.sv
module rns_modcell
   import rns_scl_pkg::*;
#(
   parameter int unsigned MODV = 7
) (
   input  logic [RW-1:0] x,
   input  logic [RW-1:0] a,
   input  logic [RW-1:0] k,
   output logic [RW-1:0] y
);

   initial begin
      assert (MODV > 1 && MODV <= 2**RW) else $error("modcell modulus out of range");
   end

   // two-operand modulo subtract, then constant multiply and reduce
   always_comb begin
      int unsigned xr;
      int unsigned ar;
      int unsigned df;
      xr = 32'(x) % MODV;
      ar = 32'(a) % MODV;
      df = (xr + MODV - ar) % MODV;
      y  = RW'((df * 32'(k)) % MODV);
   end

endmodule

// File: rtl/rns_mrc_stage.sv
module rns_mrc_stage
   import rns_scl_pkg::*;
#(
   parameter int unsigned STG = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  i_vld,
   input  logic [SW-1:0]         i_sel,
   input  logic [CH-1:0][RW-1:0] i_res,
   input  logic [CH-1:0][RW-1:0] i_dig,
   output logic                  o_vld,
   output logic [SW-1:0]         o_sel,
   output logic [CH-1:0][RW-1:0] o_res,
   output logic [CH-1:0][RW-1:0] o_dig
);

   initial begin
      assert (STG < CH - 1) else $error("mrc stage index out of range");
   end

   logic [CW-1:0]         pick_w;
   logic [RW-1:0]         dig_w;
   logic [CH-1:0][RW-1:0] nxt_w;
   logic [CH-1:0][RW-1:0] dall_w;

   always_comb begin
      pick_w      = CW'(ord_idx(32'(i_sel), STG));
      dig_w       = i_res[pick_w];
      dall_w      = i_dig;
      dall_w[STG] = dig_w;
   end

   for (genvar c = 0; c < CH; c++) begin : g_cell
      logic [RW-1:0] k_w;
      assign k_w = RW'(mrc_mul(32'(i_sel), STG, c));
      rns_modcell #(.MODV(MODS[c])) u_cell (
         .x (i_res[c]),
         .a (dig_w),
         .k (k_w),
         .y (nxt_w[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) o_vld <= 1'b0;
      else        o_vld <= i_vld;
   end

   always_ff @(posedge clk) begin
      o_sel <= i_sel;
      o_res <= nxt_w;
      o_dig <= dall_w;
   end

   // R2: each extracted mixed-radix digit lies below the modulus at its position
   p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld |-> (32'(o_dig[STG]) < mod_at(32'(o_sel), STG)))
      else $error("mixed-radix digit out of range");

endmodule

// File: rtl/rns_scale_unit.sv
module rns_scale_unit
   import rns_scl_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  i_vld,
   input  logic [SW-1:0]         i_sel,
   input  logic [CH-1:0][RW-1:0] i_res,
   input  logic [CH-1:0][RW-1:0] i_dig,
   output logic                  o_vld,
   output logic                  o_neg,
   output logic [CH-1:0][RW-1:0] o_res
);

   logic [CH-1:0][RW-1:0]   d_w;
   logic                    neg_w;
   logic [CH-1:0][SUMW-1:0] sum_w;

   logic                    a_vld;
   logic                    a_neg;
   logic [SW-1:0]           a_sel;
   logic [CH-1:0][SUMW-1:0] a_sum;
   logic [CH-1:0][RW-1:0]   b_w;

   // last digit and sign from the top digit, lower digits only on a tie
   always_comb begin
      int unsigned low;
      int unsigned top;
      d_w       = i_dig;
      d_w[CH-1] = i_res[CW'(ord_idx(32'(i_sel), CH-1))];
      low       = 0;
      for (int unsigned j = 0; j < CH - 1; j++)
         low = low + 32'(d_w[j[CW-1:0]]) * weight(32'(i_sel), j);
      top   = 32'(d_w[CH-1]);
      neg_w = (top > sgn_thr(32'(i_sel))) ||
              ((top == sgn_thr(32'(i_sel))) && (low >= sgn_rem(32'(i_sel))));
   end

   // residue of each kept scaled term, summed in binary per channel
   for (genvar c = 0; c < CH; c++) begin : g_term
      always_comb begin
         int unsigned acc;
         acc = 0;
         for (int unsigned j = 0; j < CH; j++)
            acc = acc + (32'(d_w[j[CW-1:0]]) * scl_coef(32'(i_sel), j, c)) % MODS[c];
         sum_w[c] = SUMW'(acc);
      end

      always_comb begin
         int unsigned s;
         s = 32'(a_sum[c]) % MODS[c];
         if (a_neg) s = (s + MODS[c] - neg_ofs(32'(a_sel), c)) % MODS[c];
         b_w[c] = RW'(s);
      end

      // R2: every output residue is reduced below its modulus
      p_res_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
         o_vld |-> (32'(o_res[c]) < MODS[c]))
         else $error("output residue out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_vld <= 1'b0;
         o_vld <= 1'b0;
         o_neg <= 1'b0;
      end else begin
         a_vld <= i_vld;
         o_vld <= a_vld;
         o_neg <= a_vld & a_neg;
      end
   end

   always_ff @(posedge clk) begin
      a_neg <= neg_w;
      a_sel <= i_sel;
      a_sum <= sum_w;
      o_res <= b_w;
   end

endmodule

// File: rtl/rns_signed_scaler.sv
module rns_signed_scaler
   import rns_scl_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [SW-1:0]         in_sel,
   input  logic [CH-1:0][RW-1:0] in_res,
   output logic                  out_vld,
   output logic                  out_neg,
   output logic [CH-1:0][RW-1:0] out_res
);

   localparam int unsigned TW = $clog2(LAT + 1);

   initial begin : elab_chk
      assert (CH >= 2 && (2**CW) == CH) else $error("channel count must be a power of two");
      for (int unsigned i = 0; i < CH; i++) begin
         assert (mod_of(i) > 1 && mod_of(i) <= 2**RW) else $error("modulus exceeds residue width");
         for (int unsigned j = i + 1; j < CH; j++)
            assert (gcd_u(mod_of(i), mod_of(j)) == 1) else $error("moduli not coprime");
      end
      for (int unsigned s = 0; s < NSEL; s++)
         assert (ord_cnt(s) >= 1 && ord_cnt(s) < CH) else $error("bad divisor mask");
   end

   logic                  vld_p [CH];
   logic [SW-1:0]         sel_p [CH];
   logic [CH-1:0][RW-1:0] res_p [CH];
   logic [CH-1:0][RW-1:0] dig_p [CH];

   assign vld_p[0] = in_vld;
   assign sel_p[0] = in_sel;
   assign res_p[0] = in_res;
   assign dig_p[0] = '0;

   for (genvar g = 0; g < CH - 1; g++) begin : g_stage
      rns_mrc_stage #(.STG(g)) u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .i_vld (vld_p[g]),
         .i_sel (sel_p[g]),
         .i_res (res_p[g]),
         .i_dig (dig_p[g]),
         .o_vld (vld_p[g+1]),
         .o_sel (sel_p[g+1]),
         .o_res (res_p[g+1]),
         .o_dig (dig_p[g+1])
      );
   end

   rns_scale_unit u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .i_vld (vld_p[CH-1]),
      .i_sel (sel_p[CH-1]),
      .i_res (res_p[CH-1]),
      .i_dig (dig_p[CH-1]),
      .o_vld (out_vld),
      .o_neg (out_neg),
      .o_res (out_res)
   );

   logic [TW-1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   since_rst <= '0;
      else if (since_rst != TW'(LAT)) since_rst <= since_rst + 1'b1;
   end

   // R5: result valid follows operand valid by exactly LAT cycles
   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == TW'(LAT)) |-> (out_vld == $past(in_vld, LAT)))
      else $error("result latency broken");

   for (genvar c = 0; c < CH; c++) begin : g_in_chk
      // R1: operand residues must already be reduced
      p_in_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |-> (32'(in_res[c]) < MODS[c]))
         else $error("unreduced input residue");
   end

endmodule

// File: tb/test_rns_signed_scaler.sv
`timescale 1ns/1ps
module test_rns_signed_scaler;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_vld = 1'b0;
   logic [2:0]      in_sel = '0;
   logic [3:0][3:0] in_res = '0;
   logic            out_vld;
   logic            out_neg;
   logic [3:0][3:0] out_res;

   rns_signed_scaler i_rns_signed_scaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .in_sel  (in_sel),
      .in_res  (in_res),
      .out_vld (out_vld),
      .out_neg (out_neg),
      .out_res (out_res)
   );

   always #4 clk = ~clk;

   int    mv  [4] = '{7, 11, 13, 15};
   int    fac [8] = '{7, 11, 13, 15, 77, 195, 1001, 165};
   int    nchk = 0;
   int    nfail = 0;
   int    cyc = 0;
   bit    done = 0;
   int    q_xs [$];
   int    q_sel [$];
   int    q_cyc [$];
   string q_tag [$];

   function automatic int floor_div(int a, int b);
      if (a >= 0) return a / b;
      return -((-a + b - 1) / b);
   endfunction

   function automatic int res_of(int v, int m);
      int r = v % m;
      if (r < 0) r += m;
      return r;
   endfunction

   task automatic check_out();
      if (out_vld) begin
         if (q_xs.size() == 0) begin
            nchk++; nfail++;
            $display("FAIL R5: result with no operand, actual=1 expected=0");
         end else begin
            int xs  = q_xs.pop_front();
            int sl  = q_sel.pop_front();
            int c0  = q_cyc.pop_front();
            string tg = q_tag.pop_front();
            int q   = floor_div(xs, fac[sl]);
            nchk++;
            if (cyc - c0 != 5) begin
               nfail++;
               $display("FAIL R5: latency actual=%0d expected=5", cyc - c0);
            end
            for (int c = 0; c < 4; c++) begin
               nchk++;
               if (int'(out_res[c]) != res_of(q, mv[c])) begin
                  nfail++;
                  $display("FAIL %s: ch%0d actual=%0d expected=%0d (x=%0d sel=%0d)",
                           tg, c, out_res[c], res_of(q, mv[c]), xs, sl);
               end
            end
            nchk++;
            if (out_neg != (xs < 0)) begin
               nfail++;
               $display("FAIL R4: sign actual=%0d expected=%0d (x=%0d)", out_neg, xs < 0, xs);
            end
         end
      end
   endtask

   task automatic drive(bit v, int xs, int sl, string tg);
      @(negedge clk);
      cyc++;
      check_out();
      in_vld = v;
      if (v) begin
         in_sel = 3'(sl);
         for (int c = 0; c < 4; c++) in_res[c] = 4'(res_of(xs, mv[c]));
         q_xs.push_back(xs); q_sel.push_back(sl); q_cyc.push_back(cyc); q_tag.push_back(tg);
      end else begin
         in_sel = 3'($urandom);
         in_res = 16'($urandom);
      end
   endtask

   task automatic idle_run(int n, bit chk);
      for (int i = 0; i < n; i++) begin
         drive(0, 0, 0, "R7");
         if (chk) begin
            nchk++;
            if (out_vld) begin
               nfail++;
               $display("FAIL R7: idle out_vld actual=1 expected=0");
            end
         end
      end
   endtask

   function automatic int rnd_x();
      return int'($urandom % 15015) - 7507;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      nchk++;
      if (out_vld !== 1'b0 || out_neg !== 1'b0) begin
         nfail++;
         $display("FAIL R7: reset outputs actual=%0b%0b expected=00", out_vld, out_neg);
      end
      rst_n = 1'b1;
      idle_run(3, 1);

      // R3: divisor table
      for (int s = 0; s < 8; s++) begin
         drive(1, 5000, s, "R3");
         drive(1, fac[s], s, "R3");
         drive(1, fac[s] - 1, s, "R3");
      end
      // R9: extremes; R8: negative rounding; R1: values near the sign threshold
      for (int s = 0; s < 8; s++) begin
         drive(1, 7507, s, "R9");
         drive(1, -7507, s, "R9");
         drive(1, 0, s, "R9");
         drive(1, -1, s, "R9");
         drive(1, -fac[s] - 1, s, "R8");
         drive(1, -fac[s], s, "R8");
         drive(1, -8, s, "R8");
         drive(1, 7507 - int'($urandom % 300), s, "R1");
         drive(1, -7507 + int'($urandom % 300), s, "R1");
      end
      // R6: select changes every cycle, back to back
      for (int i = 0; i < 200; i++) drive(1, rnd_x(), i % 8, "R6");
      idle_run(5, 0);
      idle_run(8, 1);
      // R2: random operands with gaps
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 4) == 0) drive(0, 0, 0, "R7");
         else                     drive(1, rnd_x(), int'($urandom % 8), "R2");
      end
      idle_run(8, 0);
      nchk++;
      if (q_xs.size() != 0) begin
         nfail++;
         $display("FAIL R5: missing results actual=%0d expected=0", q_xs.size());
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL R5: watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule